// File: doc/BRIEF.md
# Front-End Early Execution Stage

This block is an in-order, N-wide stage of single-cycle integer ALUs that runs beside register rename. Each slot of an incoming rename group carries a micro-op class, two operand descriptors and an optional value prediction for its own result. Any slot whose operands can all be obtained without the register file is executed on the spot. The stage never reads the register file. An operand can be a value that travels with the micro-op (a decoded immediate or a predicted source value). It can be the result that a slot of the immediately preceding group wrote. It can also be the prediction made for an earlier slot of the same group.

The outputs are registered in one stage. For each slot they carry the value to be written into the physical register file at dispatch, which is the computed result when the slot executed and its prediction otherwise. An executed flag tells dispatch to keep the micro-op out of the out-of-order scheduler. A check flag marks executed slots whose prediction was consumed by a later executed slot of the same group, so that the prediction is validated at commit. When dispatch stalls, the whole group is held in the output register and no new group is taken.

Top module: `fe_early_exec`

## Requirements
- R1: Class codes 0 to 7 select, in order: add, subtract (a minus b), AND, OR, XOR, shift left logical, shift right logical and shift right arithmetic. Shift amounts use only the low log2(XW) bits of operand b. A group accepted on a clock edge shows its results on the outputs from that edge on.
- R2: A slot whose class code has bit 3 set (codes 8 to 15: multi-cycle, load, store and other non-ALU work) never executes.
- R3: The operand kind is 2 bits: 0 takes the value supplied with the micro-op, 1 takes the value of slot idx of the previous group, 2 takes the prediction of slot idx of the same group, and 3 marks a producer two or more groups back. A slot with any kind-3 operand does not execute.
- R4: A kind-1 operand uses the value that slot idx of the group held in the output register wrote. If that slot wrote no value, the operand is unavailable and the slot does not execute.
- R5: A kind-1 operand is unavailable when the output register holds no group at the moment of acceptance, for example after an idle cycle.
- R6: A kind-2 operand is available only when idx is lower than the consumer's own slot number and slot idx is valid and predicted. In that case its prediction is used.
- R7: The check flag of a slot is 1 exactly when that slot executed, carries a prediction, and some later slot of the same group executed using that prediction through a kind-2 operand.
- R8: A valid slot writes a value when it executed or carries a prediction. The value is the computed result if it executed, otherwise the prediction, and 0 when nothing is written.
- R9: While the output holds a group and the stall input is high, the group and its flags stay unchanged and the ready output is low.
- R10: A slot whose valid bit is low shows executed, write and check flags of 0 and a value of 0.
- R11: After reset, and after a cycle with no acceptance and no stall, the output valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grp_valid_i | input | 1 | A rename group is offered |
| grp_ready_o | output | 1 | Stage can take the offered group |
| stall_i | input | 1 | Dispatch back-pressure |
| uop_vld_i | input | NW | Per-slot valid |
| uop_op_i | input | NW*4 | Per-slot class code |
| src_a_kind_i | input | NW*2 | Operand a kind |
| src_a_idx_i | input | NW*IW | Operand a producer slot |
| src_a_val_i | input | NW*XW | Operand a supplied value |
| src_b_kind_i | input | NW*2 | Operand b kind |
| src_b_idx_i | input | NW*IW | Operand b producer slot |
| src_b_val_i | input | NW*XW | Operand b supplied value |
| pred_vld_i | input | NW | Slot result is predicted |
| pred_val_i | input | NW*XW | Predicted result |
| out_valid_o | output | 1 | Output register holds a group |
| out_slot_vld_o | output | NW | Per-slot valid of held group |
| out_exec_o | output | NW | Slot was early-executed |
| out_wr_o | output | NW | Slot writes a value at dispatch |
| out_chk_o | output | NW | Prediction needs validation |
| out_val_o | output | NW*XW | Value to write per slot |

## Verification
The assertions watch the invariants that hold on every cycle. A held group stays unchanged under stall, and the output empties when no group is accepted and dispatch is free. Non-ALU classes, far producers and same-group references to the slot itself or to later slots never lead to execution. Executed and check flags stay consistent with the write and valid flags. The bench scenarios cover the data-dependent behaviour: exact ALU results including shift-amount truncation, bypass from the previous group including across a stall and after an idle cycle, the choice between computed value and prediction, and which producer slot gets its check flag.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned KIND_W = 2;

  localparam logic [OP_W-1:0] OP_ADD = 4'd0;
  localparam logic [OP_W-1:0] OP_SUB = 4'd1;
  localparam logic [OP_W-1:0] OP_AND = 4'd2;
  localparam logic [OP_W-1:0] OP_OR  = 4'd3;
  localparam logic [OP_W-1:0] OP_XOR = 4'd4;
  localparam logic [OP_W-1:0] OP_SLL = 4'd5;
  localparam logic [OP_W-1:0] OP_SRL = 4'd6;
  localparam logic [OP_W-1:0] OP_SRA = 4'd7;

  typedef enum logic [KIND_W-1:0] {
    SRC_DIRECT = 2'd0,
    SRC_PREV   = 2'd1,
    SRC_SAME   = 2'd2,
    SRC_FAR    = 2'd3
  } src_kind_e;
endpackage

// File: rtl/ee_alu.sv
module ee_alu #(
  parameter int unsigned XW = 64
) (
  input  logic [ee_pkg::OP_W-1:0] op_i,
  input  logic [XW-1:0]           a_i,
  input  logic [XW-1:0]           b_i,
  output logic [XW-1:0]           res_o
);
  localparam int unsigned SW = $clog2(XW);

  logic [SW-1:0] sh;
  assign sh = b_i[SW-1:0];

  always_comb begin
    unique case (op_i)
      ee_pkg::OP_ADD: res_o = a_i + b_i;
      ee_pkg::OP_SUB: res_o = a_i - b_i;
      ee_pkg::OP_AND: res_o = a_i & b_i;
      ee_pkg::OP_OR:  res_o = a_i | b_i;
      ee_pkg::OP_XOR: res_o = a_i ^ b_i;
      ee_pkg::OP_SLL: res_o = a_i << sh;
      ee_pkg::OP_SRL: res_o = a_i >> sh;
      ee_pkg::OP_SRA: res_o = XW'($signed(a_i) >>> sh);
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/ee_opnd_sel.sv
module ee_opnd_sel #(
  parameter int unsigned NW   = 4,
  parameter int unsigned XW   = 64,
  parameter int unsigned IW   = 2,
  parameter int unsigned SLOT = 0
) (
  input  logic [ee_pkg::KIND_W-1:0] kind_i,
  input  logic [IW-1:0]             idx_i,
  input  logic [XW-1:0]             val_i,
  input  logic [NW*XW-1:0]          byp_val_i,
  input  logic [NW-1:0]             byp_ok_i,
  input  logic [NW*XW-1:0]          prd_val_i,
  input  logic [NW-1:0]             prd_ok_i,
  output logic [XW-1:0]             opnd_o,
  output logic                      ok_o,
  output logic [NW-1:0]             same_hit_o
);
  import ee_pkg::*;

  // slots strictly ahead of this one in the group
  localparam logic [NW:0]   LOWER_W = (NW+1)'((NW+1)'(1) << SLOT) - (NW+1)'(1);
  localparam logic [NW-1:0] LOWER   = LOWER_W[NW-1:0];

  logic in_rng;
  assign in_rng = 32'(idx_i) < NW;

  always_comb begin
    opnd_o     = '0;
    ok_o       = 1'b0;
    same_hit_o = '0;
    unique case (src_kind_e'(kind_i))
      SRC_DIRECT: begin
        ok_o   = 1'b1;
        opnd_o = val_i;
      end
      SRC_PREV: if (in_rng) begin
        ok_o   = byp_ok_i[idx_i];
        opnd_o = byp_val_i[idx_i*XW +: XW];
      end
      SRC_SAME: if (in_rng && LOWER[idx_i]) begin
        ok_o               = prd_ok_i[idx_i];
        opnd_o             = prd_val_i[idx_i*XW +: XW];
        same_hit_o[idx_i]  = prd_ok_i[idx_i];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ee_slot.sv
module ee_slot #(
  parameter int unsigned NW   = 4,
  parameter int unsigned XW   = 64,
  parameter int unsigned IW   = 2,
  parameter int unsigned SLOT = 0
) (
  input  logic                      vld_i,
  input  logic [ee_pkg::OP_W-1:0]   op_i,
  input  logic [ee_pkg::KIND_W-1:0] ka_i,
  input  logic [IW-1:0]             ia_i,
  input  logic [XW-1:0]             va_i,
  input  logic [ee_pkg::KIND_W-1:0] kb_i,
  input  logic [IW-1:0]             ib_i,
  input  logic [XW-1:0]             vb_i,
  input  logic                      pvld_i,
  input  logic [XW-1:0]             pval_i,
  input  logic [NW*XW-1:0]          byp_val_i,
  input  logic [NW-1:0]             byp_ok_i,
  input  logic [NW*XW-1:0]          prd_val_i,
  input  logic [NW-1:0]             prd_ok_i,
  output logic                      exec_o,
  output logic                      wr_o,
  output logic [XW-1:0]             val_o,
  output logic [NW-1:0]             use_o
);
  logic [XW-1:0] opa, opb, res;
  logic          a_ok, b_ok;
  logic [NW-1:0] hit_a, hit_b;

  ee_opnd_sel #(.NW(NW), .XW(XW), .IW(IW), .SLOT(SLOT)) u_sel_a (
    .kind_i(ka_i), .idx_i(ia_i), .val_i(va_i),
    .byp_val_i(byp_val_i), .byp_ok_i(byp_ok_i),
    .prd_val_i(prd_val_i), .prd_ok_i(prd_ok_i),
    .opnd_o(opa), .ok_o(a_ok), .same_hit_o(hit_a)
  );

  ee_opnd_sel #(.NW(NW), .XW(XW), .IW(IW), .SLOT(SLOT)) u_sel_b (
    .kind_i(kb_i), .idx_i(ib_i), .val_i(vb_i),
    .byp_val_i(byp_val_i), .byp_ok_i(byp_ok_i),
    .prd_val_i(prd_val_i), .prd_ok_i(prd_ok_i),
    .opnd_o(opb), .ok_o(b_ok), .same_hit_o(hit_b)
  );

  ee_alu #(.XW(XW)) u_alu (.op_i(op_i), .a_i(opa), .b_i(opb), .res_o(res));

  // class bit 3 set: not a single-cycle ALU micro-op
  assign exec_o = vld_i && !op_i[3] && a_ok && b_ok;
  assign wr_o   = vld_i && (exec_o || pvld_i);
  assign val_o  = exec_o ? res : (wr_o ? pval_i : '0);
  assign use_o  = exec_o ? (hit_a | hit_b) : '0;
endmodule

// File: rtl/fe_early_exec.sv
module fe_early_exec #(
  parameter int unsigned NW = 4,
  parameter int unsigned XW = 64,
  parameter int unsigned IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         grp_valid_i,
  output logic                         grp_ready_o,
  input  logic                         stall_i,
  input  logic [NW-1:0]                uop_vld_i,
  input  logic [NW*ee_pkg::OP_W-1:0]   uop_op_i,
  input  logic [NW*ee_pkg::KIND_W-1:0] src_a_kind_i,
  input  logic [NW*IW-1:0]             src_a_idx_i,
  input  logic [NW*XW-1:0]             src_a_val_i,
  input  logic [NW*ee_pkg::KIND_W-1:0] src_b_kind_i,
  input  logic [NW*IW-1:0]             src_b_idx_i,
  input  logic [NW*XW-1:0]             src_b_val_i,
  input  logic [NW-1:0]                pred_vld_i,
  input  logic [NW*XW-1:0]             pred_val_i,
  output logic                         out_valid_o,
  output logic [NW-1:0]                out_slot_vld_o,
  output logic [NW-1:0]                out_exec_o,
  output logic [NW-1:0]                out_wr_o,
  output logic [NW-1:0]                out_chk_o,
  output logic [NW*XW-1:0]             out_val_o
);
  localparam int unsigned OPW = ee_pkg::OP_W;
  localparam int unsigned KW  = ee_pkg::KIND_W;

  logic              valid_q;
  logic [NW-1:0]     slot_vld_q, exec_q, wr_q, chk_q;
  logic [NW*XW-1:0]  val_q;

  logic              acc;
  logic [NW-1:0]     byp_ok, prd_ok;
  logic [NW-1:0]     exec_d, wr_d, chk_d, used_any;
  logic [NW*XW-1:0]  val_d;
  logic [NW-1:0]     use_d [NW];

  assign grp_ready_o = !(valid_q && stall_i);
  assign acc         = grp_valid_i && grp_ready_o;
  // bypass source is the group currently held in the output register
  assign byp_ok      = {NW{valid_q}} & wr_q;
  assign prd_ok      = uop_vld_i & pred_vld_i;

  for (genvar g = 0; g < NW; g++) begin : g_slot
    ee_slot #(.NW(NW), .XW(XW), .IW(IW), .SLOT(g)) u_slot (
      .vld_i    (uop_vld_i[g]),
      .op_i     (uop_op_i[g*OPW +: OPW]),
      .ka_i     (src_a_kind_i[g*KW +: KW]),
      .ia_i     (src_a_idx_i[g*IW +: IW]),
      .va_i     (src_a_val_i[g*XW +: XW]),
      .kb_i     (src_b_kind_i[g*KW +: KW]),
      .ib_i     (src_b_idx_i[g*IW +: IW]),
      .vb_i     (src_b_val_i[g*XW +: XW]),
      .pvld_i   (pred_vld_i[g]),
      .pval_i   (pred_val_i[g*XW +: XW]),
      .byp_val_i(val_q),
      .byp_ok_i (byp_ok),
      .prd_val_i(pred_val_i),
      .prd_ok_i (prd_ok),
      .exec_o   (exec_d[g]),
      .wr_o     (wr_d[g]),
      .val_o    (val_d[g*XW +: XW]),
      .use_o    (use_d[g])
    );
  end

  always_comb begin
    used_any = '0;
    for (int j = 0; j < NW; j++) used_any |= use_d[j];
  end

  assign chk_d = exec_d & pred_vld_i & used_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= 1'b0;
      slot_vld_q <= '0;
      exec_q     <= '0;
      wr_q       <= '0;
      chk_q      <= '0;
      val_q      <= '0;
    end else if (acc) begin
      valid_q    <= 1'b1;
      slot_vld_q <= uop_vld_i;
      exec_q     <= exec_d;
      wr_q       <= wr_d;
      chk_q      <= chk_d;
      val_q      <= val_d;
    end else if (!stall_i) begin
      valid_q    <= 1'b0;
      slot_vld_q <= '0;
      exec_q     <= '0;
      wr_q       <= '0;
      chk_q      <= '0;
    end
  end

  assign out_valid_o    = valid_q;
  assign out_slot_vld_o = slot_vld_q;
  assign out_exec_o     = exec_q;
  assign out_wr_o       = wr_q;
  assign out_chk_o      = chk_q;
  assign out_val_o      = val_q;
endmodule

// File: rtl/fe_early_exec_chk.sv
module fe_early_exec_chk #(
  parameter int unsigned NW = 4,
  parameter int unsigned XW = 64,
  parameter int unsigned IW = 2
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         grp_valid_i,
  input logic                         grp_ready_o,
  input logic                         stall_i,
  input logic [NW-1:0]                uop_vld_i,
  input logic [NW*ee_pkg::OP_W-1:0]   uop_op_i,
  input logic [NW*ee_pkg::KIND_W-1:0] src_a_kind_i,
  input logic [NW*IW-1:0]             src_a_idx_i,
  input logic [NW*ee_pkg::KIND_W-1:0] src_b_kind_i,
  input logic                         out_valid_o,
  input logic [NW-1:0]                out_slot_vld_o,
  input logic [NW-1:0]                out_exec_o,
  input logic [NW-1:0]                out_wr_o,
  input logic [NW-1:0]                out_chk_o,
  input logic [NW*XW-1:0]             out_val_o
);
  localparam int unsigned OPW = ee_pkg::OP_W;
  localparam int unsigned KW  = ee_pkg::KIND_W;

  logic acc;
  assign acc = grp_valid_i && grp_ready_o;

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && stall_i |=> out_valid_o && $stable(out_val_o) && $stable(out_exec_o)
                               && $stable(out_wr_o) && $stable(out_chk_o));

  a_r11_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc && !stall_i |=> !out_valid_o);

  a_r10_idle_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((out_exec_o | out_wr_o | out_chk_o) & ~out_slot_vld_o) == '0);

  a_r8_exec_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_exec_o & ~out_wr_o) == '0);

  a_r7_chk_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_chk_o & ~out_exec_o) == '0);

  for (genvar j = 0; j < NW; j++) begin : g_slot
    a_r2_non_alu: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc && uop_op_i[j*OPW+3] |=> !out_exec_o[j]);

    a_r3_far: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc && (src_a_kind_i[j*KW +: KW] == 2'd3 || src_b_kind_i[j*KW +: KW] == 2'd3)
      |=> !out_exec_o[j]);

    a_r6_same_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc && src_a_kind_i[j*KW +: KW] == 2'd2 && 32'(src_a_idx_i[j*IW +: IW]) >= j
      |=> !out_exec_o[j]);
  end
endmodule

bind fe_early_exec fe_early_exec_chk #(.NW(NW), .XW(XW), .IW(IW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .grp_valid_i(grp_valid_i), .grp_ready_o(grp_ready_o),
  .stall_i(stall_i), .uop_vld_i(uop_vld_i), .uop_op_i(uop_op_i),
  .src_a_kind_i(src_a_kind_i), .src_a_idx_i(src_a_idx_i), .src_b_kind_i(src_b_kind_i),
  .out_valid_o(out_valid_o), .out_slot_vld_o(out_slot_vld_o), .out_exec_o(out_exec_o),
  .out_wr_o(out_wr_o), .out_chk_o(out_chk_o), .out_val_o(out_val_o)
);

// File: tb/tb_fe_early_exec.sv
`timescale 1ns/1ps
module tb_fe_early_exec;
  localparam int NW = 4;
  localparam int XW = 64;
  localparam int IW = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic              grp_valid_i = 1'b0, grp_ready_o, stall_i = 1'b0;
  logic [NW-1:0]     uop_vld_i = '0, pred_vld_i = '0;
  logic [NW*4-1:0]   uop_op_i = '0;
  logic [NW*2-1:0]   src_a_kind_i = '0, src_b_kind_i = '0;
  logic [NW*IW-1:0]  src_a_idx_i = '0, src_b_idx_i = '0;
  logic [NW*XW-1:0]  src_a_val_i = '0, src_b_val_i = '0, pred_val_i = '0;
  logic              out_valid_o;
  logic [NW-1:0]     out_slot_vld_o, out_exec_o, out_wr_o, out_chk_o;
  logic [NW*XW-1:0]  out_val_o;

  fe_early_exec #(.NW(NW), .XW(XW)) dut (.*);

  // per-slot stimulus
  bit            s_vld[NW], s_pvld[NW];
  logic [3:0]    s_op[NW];
  logic [1:0]    s_ka[NW], s_kb[NW];
  logic [IW-1:0] s_ia[NW], s_ib[NW];
  logic [XW-1:0] s_va[NW], s_vb[NW], s_pv[NW];

  // model of the group held at the output
  bit            m_ok;
  bit            m_wr[NW];
  logic [XW-1:0] m_val[NW];

  typedef struct {
    logic [NW-1:0]    vld, exec, wr, chk;
    logic [NW*XW-1:0] val;
    string            tag;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0;

  function automatic logic [XW-1:0] alu_ref(logic [3:0] op, logic [XW-1:0] a, logic [XW-1:0] b);
    case (op)
      4'd0: return a + b;
      4'd1: return a - b;
      4'd2: return a & b;
      4'd3: return a | b;
      4'd4: return a ^ b;
      4'd5: return a << b[5:0];
      4'd6: return a >> b[5:0];
      4'd7: return XW'($signed(a) >>> b[5:0]);
      default: return '0;
    endcase
  endfunction

  task automatic get_opnd(input logic [1:0] k, input logic [IW-1:0] idx, input logic [XW-1:0] v,
                          input int j, output bit ok, output logic [XW-1:0] r);
    ok = 0; r = '0;
    case (k)
      2'd0: begin ok = 1; r = v; end
      2'd1: begin ok = m_ok && m_wr[idx]; r = m_val[idx]; end
      2'd2: begin ok = (int'(idx) < j) && s_vld[idx] && s_pvld[idx]; r = s_pv[idx]; end
      default: ;
    endcase
  endtask

  task automatic build_exp(output exp_t e);
    bit aok, bok;
    logic [XW-1:0] a, b, v;
    e.vld = '0; e.exec = '0; e.wr = '0; e.chk = '0; e.val = '0;
    for (int j = 0; j < NW; j++) begin
      get_opnd(s_ka[j], s_ia[j], s_va[j], j, aok, a);
      get_opnd(s_kb[j], s_ib[j], s_vb[j], j, bok, b);
      e.vld[j]  = s_vld[j];
      e.exec[j] = s_vld[j] && s_op[j] < 8 && aok && bok;
      e.wr[j]   = s_vld[j] && (e.exec[j] || s_pvld[j]);
      v = e.exec[j] ? alu_ref(s_op[j], a, b) : (e.wr[j] ? s_pv[j] : '0);
      e.val[j*XW +: XW] = v;
    end
    for (int k = 0; k < NW; k++)
      for (int j = k + 1; j < NW; j++)
        if (e.exec[k] && s_pvld[k] && e.exec[j] &&
            ((s_ka[j] == 2'd2 && s_ia[j] == IW'(k)) || (s_kb[j] == 2'd2 && s_ib[j] == IW'(k))))
          e.chk[k] = 1'b1;
  endtask

  task automatic clear_grp();
    for (int j = 0; j < NW; j++) begin
      s_vld[j] = 1; s_pvld[j] = 0; s_op[j] = 4'd0;
      s_ka[j] = 2'd0; s_kb[j] = 2'd0; s_ia[j] = '0; s_ib[j] = '0;
      s_va[j] = XW'(j + 1); s_vb[j] = XW'(10 * j + 3); s_pv[j] = {32'hC0DE_0000, 32'(j)};
    end
  endtask

  task automatic cycle(input bit send, input bit stl, input string tag);
    exp_t e;
    @(negedge clk_i);
    for (int j = 0; j < NW; j++) begin
      uop_vld_i[j]             = s_vld[j];
      pred_vld_i[j]            = s_pvld[j];
      uop_op_i[j*4 +: 4]       = s_op[j];
      src_a_kind_i[j*2 +: 2]   = s_ka[j];
      src_b_kind_i[j*2 +: 2]   = s_kb[j];
      src_a_idx_i[j*IW +: IW]  = s_ia[j];
      src_b_idx_i[j*IW +: IW]  = s_ib[j];
      src_a_val_i[j*XW +: XW]  = s_va[j];
      src_b_val_i[j*XW +: XW]  = s_vb[j];
      pred_val_i[j*XW +: XW]   = s_pv[j];
    end
    grp_valid_i = send;
    stall_i     = stl;
    #1;
    if (send && grp_ready_o) begin
      build_exp(e);
      e.tag = tag;
      exp_q.push_back(e);
      m_ok = 1;
      for (int j = 0; j < NW; j++) begin
        m_wr[j]  = e.wr[j];
        m_val[j] = e.val[j*XW +: XW];
      end
    end else if (!stl) begin
      m_ok = 0;
    end
  endtask

  task automatic check(input bit ok, input string what, input logic [XW-1:0] got, input logic [XW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  // monitor: compares each newly loaded group against the scoreboard
  logic acc_d;
  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) acc_d <= 1'b0;
    else         acc_d <= grp_valid_i && grp_ready_o;

  always @(negedge clk_i) begin
    if (acc_d) begin
      exp_t e;
      if (exp_q.size() == 0) begin
        check(0, "scoreboard underflow R11", 64'(out_valid_o), 64'd0);
      end else begin
        e = exp_q.pop_front();
        check(out_valid_o == 1'b1, {e.tag, " out_valid"}, 64'(out_valid_o), 64'd1);
        for (int j = 0; j < NW; j++) begin
          n_chk++;
          if (out_slot_vld_o[j] !== e.vld[j] || out_exec_o[j] !== e.exec[j] ||
              out_wr_o[j] !== e.wr[j] || out_chk_o[j] !== e.chk[j] ||
              out_val_o[j*XW +: XW] !== e.val[j*XW +: XW]) begin
            n_fail++;
            $display("FAIL %s slot %0d: got vld=%b exec=%b wr=%b chk=%b val=%h expected vld=%b exec=%b wr=%b chk=%b val=%h",
                     e.tag, j, out_slot_vld_o[j], out_exec_o[j], out_wr_o[j], out_chk_o[j],
                     out_val_o[j*XW +: XW], e.vld[j], e.exec[j], e.wr[j], e.chk[j],
                     e.val[j*XW +: XW]);
          end
        end
      end
    end
  end

  task automatic run_tests();
    logic [NW*XW-1:0] cap_val;
    logic [NW-1:0]    cap_exec;

    // R11: reset state
    #1;
    check(out_valid_o == 0, "R11 reset out_valid", 64'(out_valid_o), 64'd0);
    check(grp_ready_o == 1, "R11 reset ready", 64'(grp_ready_o), 64'd1);
    repeat (3) @(posedge clk_i);
    rst_ni = 1'b1;

    // R1: arithmetic and logic
    clear_grp();
    s_op[0] = 4'd0; s_va[0] = '1;                    s_vb[0] = 64'd2;
    s_op[1] = 4'd1; s_va[1] = 64'd5;                 s_vb[1] = 64'd7;
    s_op[2] = 4'd2; s_va[2] = 64'hF0F0_1234_5678_9ABC; s_vb[2] = 64'h0FF0_FFFF_0000_FFFF;
    s_op[3] = 4'd3; s_va[3] = 64'h8000_0000_0000_0000; s_vb[3] = 64'h1;
    cycle(1, 0, "R1 add/sub/and/or");
    // R1: xor and shifts, shift amount 70 uses low bits (6)
    clear_grp();
    s_op[0] = 4'd4; s_va[0] = 64'hAAAA_5555_AAAA_5555; s_vb[0] = '1;
    s_op[1] = 4'd5; s_va[1] = 64'h3;                 s_vb[1] = 64'd70;
    s_op[2] = 4'd6; s_va[2] = 64'h8000_0000_0000_0001; s_vb[2] = 64'd63;
    s_op[3] = 4'd7; s_va[3] = 64'h8000_0000_0000_0F00; s_vb[3] = 64'd4;
    cycle(1, 0, "R1 xor/shifts");
    // R2 and R8: non-ALU classes never execute, prediction still written
    clear_grp();
    s_op[0] = 4'd8; s_op[1] = 4'd9; s_op[2] = 4'd12; s_op[3] = 4'd15;
    s_pvld[1] = 1; s_pv[1] = 64'h1234_5678_9ABC_DEF0;
    cycle(1, 0, "R2 R8 non-ALU");
    // R3: far producer blocks execution; slot 1 predicted
    clear_grp();
    s_kb[0] = 2'd3; s_ka[1] = 2'd3; s_pvld[1] = 1; s_pv[1] = 64'h55;
    s_op[2] = 4'd1; s_va[2] = 64'd100; s_vb[2] = 64'd1;
    cycle(1, 0, "R3 far producer");
    // R4: bypass from previous group
    clear_grp();
    s_ka[0] = 2'd1; s_ia[0] = 2'd2;                        // prev slot 2 executed
    s_ka[1] = 2'd1; s_ia[1] = 2'd0;                        // prev slot 0 wrote nothing
    s_kb[2] = 2'd1; s_ib[2] = 2'd1; s_op[2] = 4'd4;        // prev slot 1 prediction
    s_ka[3] = 2'd1; s_ia[3] = 2'd3; s_kb[3] = 2'd1; s_ib[3] = 2'd2;
    cycle(1, 0, "R4 bypass");
    // R5: idle cycle kills the bypass
    clear_grp();
    cycle(0, 0, "");
    s_ka[0] = 2'd1; s_ia[0] = 2'd0; s_ka[1] = 2'd1; s_ia[1] = 2'd1;
    cycle(1, 0, "R5 bypass after idle");
    // R6 and R7: same-group predictions
    clear_grp();
    s_pvld[0] = 1; s_pv[0] = 64'd1000;
    s_ka[1] = 2'd2; s_ia[1] = 2'd3; s_pvld[3] = 1;          // later slot: not allowed
    s_ka[2] = 2'd2; s_ia[2] = 2'd0; s_op[2] = 4'd1;          // uses slot 0 prediction
    s_kb[3] = 2'd2; s_ib[3] = 2'd1;                          // slot 1 not predicted
    cycle(1, 0, "R6 R7 same group");
    // R7: consumer that does not execute leaves no check flag
    clear_grp();
    s_pvld[0] = 1; s_pv[0] = 64'd77;
    s_op[1] = 4'd9; s_ka[1] = 2'd2; s_ia[1] = 2'd0;
    s_ka[2] = 2'd2; s_ia[2] = 2'd2; s_pvld[2] = 1;          // self reference
    cycle(1, 0, "R7 R6 no consumer");
    // R10: invalid slots
    clear_grp();
    s_vld[0] = 0; s_pvld[0] = 1; s_vld[2] = 0; s_pvld[2] = 1;
    s_ka[1] = 2'd2; s_ia[1] = 2'd0;                          // refers to invalid slot
    cycle(1, 0, "R10 invalid slots");
    // R9: stall holds the group
    clear_grp();
    s_op[0] = 4'd2; s_op[1] = 4'd5; s_pvld[2] = 1; s_vld[3] = 0;
    cycle(1, 0, "R9 group before stall");
    cycle(0, 1, "");
    cap_val = out_val_o; cap_exec = out_exec_o;
    for (int i = 0; i < 3; i++) begin
      clear_grp(); s_op[0] = 4'd1;
      cycle(1, 1, "R9 offered under stall");
      check(grp_ready_o == 0, "R9 ready low under stall", 64'(grp_ready_o), 64'd0);
      check(out_val_o == cap_val && out_exec_o == cap_exec && out_valid_o,
            "R9 held value", out_val_o[XW-1:0], cap_val[XW-1:0]);
    end
    // R4: bypass from the group that was held
    clear_grp();
    s_ka[0] = 2'd1; s_ia[0] = 2'd1; s_ka[1] = 2'd1; s_ia[1] = 2'd2;
    s_ka[2] = 2'd1; s_ia[2] = 2'd3;
    cycle(1, 0, "R4 bypass after stall");

    // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      for (int j = 0; j < NW; j++) begin
        s_vld[j]  = ($urandom_range(0, 7) != 0);
        s_pvld[j] = $urandom_range(0, 1);
        s_op[j]   = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(8, 15)) : 4'($urandom_range(0, 7));
        s_ka[j]   = 2'($urandom_range(0, 3));
        s_kb[j]   = ($urandom_range(0, 1) == 0) ? 2'd0 : 2'($urandom_range(0, 3));
        s_ia[j]   = IW'($urandom_range(0, NW - 1));
        s_ib[j]   = IW'($urandom_range(0, NW - 1));
        s_va[j]   = {$urandom, $urandom};
        s_vb[j]   = {$urandom, $urandom};
        s_pv[j]   = {$urandom, $urandom};
      end
      cycle($urandom_range(0, 5) != 0, $urandom_range(0, 4) == 0, "random R1 R4 R6 R7 R8");
    end
    clear_grp();
    cycle(0, 0, "");
    cycle(0, 0, "");
    check(out_valid_o == 0, "R11 drained", 64'(out_valid_o), 64'd0);
    check(exp_q.size() == 0, "R8 scoreboard empty", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    m_ok = 0;
    for (int j = 0; j < NW; j++) begin m_wr[j] = 0; m_val[j] = '0; end
    clear_grp();
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog R11: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule